// File: doc/BRIEF.md
# Clock Mode and Frequency Multiplier Controller

This block chooses how the system clock is produced from a static oscillator mode code and a software enable bit. It decides whether a times-four frequency multiplier path may run. For example, a 10 MHz input gives a 40 MHz internal clock when the path is selected. The analog multiplier is outside the block. The block drives its enable and a select signal for the downstream clock mux, and it receives a lock-status level back.

Execution is held back after reset and after wake from sleep. The hold lasts until a startup wait has expired, which applies to the external-clock modes. When the multiplier is in use, the hold also lasts until a lock timer has expired. The auxiliary oscillator pin either carries the reference clock divided by four or is handed to the port logic as a general purpose I/O bit. In the crystal and RC modes the pin stays part of the oscillator and is not driven.

Mode codes: 0 low-power crystal, 1 crystal, 2 high-speed crystal (software multiplier), 3 RC, 4 external clock (software multiplier), 5 external clock with I/O (software multiplier), 6 high-speed crystal with multiplier forced on, 7 external clock with multiplier forced on, 8 external clock with I/O and multiplier forced on. Codes 9 to 15 are undefined.

Top module: `clkmode_pll_ctrl`

## Requirements
- R1: For mode codes 0, 1, 3 and 9 to 15, pll_enable and clk_sel_4x stay 0. A write of 1 to the software enable in these modes is ignored.
- R2: In software modes 2, 4 and 5, pll_enable and clk_sel_4x are 0 after reset. A write of 1 (pll_en_wr with pll_en_wdata=1) sets pll_enable from the edge that takes the write.
- R3: In a software mode, clk_sel_4x rises after LOCK_CYCLES+1 rising edges, counting the edge that takes the enable write, provided pll_lock is high.
- R4: In forced modes 6, 7 and 8, pll_enable is 1 from reset whatever the software bit is. A write of 0 has no effect.
- R5: After reset is released, exec_ready rises on edge number max(S, L)+1. S is START_CYCLES for external-clock modes (codes 4, 5, 7, 8 and 9 to 15) and 0 otherwise. L is LOCK_CYCLES when the multiplier is on at reset and 0 otherwise. Once high, exec_ready stays high until sleep.
- R6: In modes 4, 7 and 9 to 15, aux_oe is 1. After k edges since reset, aux_out is 1 exactly when k mod 4 is 2 or 3, which gives a 50% duty cycle.
- R7: In modes 5 and 8, aux_out equals gpio_out and aux_oe equals gpio_oe.
- R8: In crystal and RC modes 0, 1, 2, 3 and 6, aux_oe and aux_out are 0.
- R9: A sleep_req pulse without wake_evt drives exec_ready and pll_enable to 0 from the next edge. A wake_evt restarts both timers. exec_ready then rises on edge number max(S, L)+2, counting the wake edge.
- R10: Any reset clears the software enable bit. After reset, a software mode runs at 1x with pll_enable=0.
- R11: While the multiplier is enabled, clk_sel_4x follows pll_lock in the same cycle, dropping to 0 when pll_lock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Enter sleep (one-cycle pulse) |
| wake_evt | input | 1 | Wake from sleep (one-cycle pulse) |
| mode_cfg | input | MODE_W | Oscillator mode code, static outside reset |
| pll_en_wr | input | 1 | Software enable write strobe |
| pll_en_wdata | input | 1 | Software enable write value |
| pll_lock | input | 1 | Lock status level from the multiplier |
| gpio_out | input | 1 | Port data for the auxiliary pin in I/O modes |
| gpio_oe | input | 1 | Port direction for the auxiliary pin in I/O modes |
| clk_sel_4x | output | 1 | Select the 4x clock path |
| pll_enable | output | 1 | Enable the multiplier |
| exec_ready | output | 1 | Execution may run |
| aux_out | output | 1 | Auxiliary pin value |
| aux_oe | output | 1 | Auxiliary pin output enable |

## Verification
All sixteen mode codes are swept through reset. Each one is checked for the edge on which exec_ready rises, the reset value of pll_enable and the auxiliary pin waveform. This separates the crystal, external and I/O variants and the forced, software and disallowed multiplier classes by their distinct startup counts. A software enable write is then tried in every mode; the lock count separates software modes from forced modes, and modes where the write must be ignored show no change. Lock loss, sleep and wake, and a reset that clears a set enable bit are tried on chosen modes, with different lock and start limits, so that a swapped timer gives a wrong count.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] CM_LOWPWR     = 4'd0;
   localparam logic [CODE_W-1:0] CM_XTAL       = 4'd1;
   localparam logic [CODE_W-1:0] CM_XTAL_HS    = 4'd2;
   localparam logic [CODE_W-1:0] CM_RC         = 4'd3;
   localparam logic [CODE_W-1:0] CM_EXT        = 4'd4;
   localparam logic [CODE_W-1:0] CM_EXT_IO     = 4'd5;
   localparam logic [CODE_W-1:0] CM_XTAL_HS_X4 = 4'd6;
   localparam logic [CODE_W-1:0] CM_EXT_X4     = 4'd7;
   localparam logic [CODE_W-1:0] CM_EXT_IO_X4  = 4'd8;

   typedef struct packed {
      logic mul_ok;     // multiplier may be enabled
      logic mul_fixed;  // multiplier forced on by the code
      logic ext_src;    // external clock source, startup wait applies
      logic aux_gpio;   // auxiliary pin handed to port logic
   } clkmode_attr_t;

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
   import clkmode_pkg::*;
#(
   parameter int MODE_W = 4
) (
   input  logic [MODE_W-1:0] mode_cfg,
   output clkmode_attr_t     attr
);

   if (MODE_W < CODE_W) begin : g_bad_width
      $error("clkmode_decode: MODE_W must be at least %0d", CODE_W);
   end

   localparam int HI_W = (MODE_W > CODE_W) ? MODE_W - CODE_W : 1;

   logic [CODE_W-1:0] code;
   logic              high_set;

   assign code = mode_cfg[CODE_W-1:0];

   if (MODE_W > CODE_W) begin : g_wide
      logic [HI_W-1:0] hi_bits;
      assign hi_bits  = mode_cfg[MODE_W-1:MODE_W-HI_W];
      assign high_set = |hi_bits;
   end else begin : g_exact
      assign high_set = 1'b0;
   end

   always_comb begin
      attr = '{mul_ok: 1'b0, mul_fixed: 1'b0, ext_src: 1'b1, aux_gpio: 1'b0};
      if (!high_set) begin
         unique case (code)
            CM_LOWPWR, CM_XTAL, CM_RC:
               attr = '{mul_ok: 1'b0, mul_fixed: 1'b0, ext_src: 1'b0, aux_gpio: 1'b0};
            CM_XTAL_HS:
               attr = '{mul_ok: 1'b1, mul_fixed: 1'b0, ext_src: 1'b0, aux_gpio: 1'b0};
            CM_EXT:
               attr = '{mul_ok: 1'b1, mul_fixed: 1'b0, ext_src: 1'b1, aux_gpio: 1'b0};
            CM_EXT_IO:
               attr = '{mul_ok: 1'b1, mul_fixed: 1'b0, ext_src: 1'b1, aux_gpio: 1'b1};
            CM_XTAL_HS_X4:
               attr = '{mul_ok: 1'b1, mul_fixed: 1'b1, ext_src: 1'b0, aux_gpio: 1'b0};
            CM_EXT_X4:
               attr = '{mul_ok: 1'b1, mul_fixed: 1'b1, ext_src: 1'b1, aux_gpio: 1'b0};
            CM_EXT_IO_X4:
               attr = '{mul_ok: 1'b1, mul_fixed: 1'b1, ext_src: 1'b1, aux_gpio: 1'b1};
            default:
               attr = '{mul_ok: 1'b0, mul_fixed: 1'b0, ext_src: 1'b1, aux_gpio: 1'b0};
         endcase
      end
   end

endmodule

// File: rtl/clkmode_timer.sv
module clkmode_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic done
);

   if (LIMIT < 0) begin : g_bad_limit
      $error("clkmode_timer: LIMIT must not be negative");
   end

   if (LIMIT == 0) begin : g_none
      assign done = 1'b1;
   end else begin : g_count
      localparam int CNT_W = $clog2(LIMIT + 1);
      localparam logic [CNT_W-1:0] END_VAL = CNT_W'(LIMIT);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (restart) begin
            cnt_q <= '0;
         end else if (run && (cnt_q != END_VAL)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign done = (cnt_q == END_VAL);
   end

endmodule

// File: rtl/clkmode_auxpin.sv
module clkmode_auxpin #(
   parameter int DIV_LOG2 = 2
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic drive_clk,
   input  logic hand_to_port,
   input  logic gpio_out,
   input  logic gpio_oe,
   output logic aux_out,
   output logic aux_oe
);

   if (DIV_LOG2 < 1) begin : g_bad_div
      $error("clkmode_auxpin: DIV_LOG2 must be at least 1");
   end

   logic [DIV_LOG2-1:0] div_q;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   always_comb begin
      if (hand_to_port) begin
         aux_out = gpio_out;
         aux_oe  = gpio_oe;
      end else if (drive_clk) begin
         aux_out = div_q[DIV_LOG2-1];
         aux_oe  = 1'b1;
      end else begin
         aux_out = 1'b0;
         aux_oe  = 1'b0;
      end
   end

endmodule

// File: rtl/clkmode_pll_ctrl.sv
module clkmode_pll_ctrl
   import clkmode_pkg::*;
#(
   parameter int LOCK_CYCLES  = 40,
   parameter int START_CYCLES = 12,
   parameter int MODE_W       = 4,
   parameter int DIV_LOG2     = 2
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              wake_evt,
   input  logic [MODE_W-1:0] mode_cfg,
   input  logic              pll_en_wr,
   input  logic              pll_en_wdata,
   input  logic              pll_lock,
   input  logic              gpio_out,
   input  logic              gpio_oe,
   output logic              clk_sel_4x,
   output logic              pll_enable,
   output logic              exec_ready,
   output logic              aux_out,
   output logic              aux_oe
);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("clkmode_pll_ctrl: LOCK_CYCLES must be at least 1");
   end
   if (START_CYCLES < 0) begin : g_bad_start
      $error("clkmode_pll_ctrl: START_CYCLES must not be negative");
   end

   clkmode_attr_t attr;
   logic          sw_en_q;
   logic          asleep_q;
   logic          ready_q;
   logic          mul_want;
   logic          lock_done;
   logic          start_done;
   logic          start_ok;
   logic          go_sleep;

   clkmode_decode #(.MODE_W(MODE_W)) u_decode (
      .mode_cfg (mode_cfg),
      .attr     (attr)
   );

   // software enable bit: cleared by reset, writable only where allowed
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         sw_en_q <= 1'b0;
      end else if (pll_en_wr && attr.mul_ok && !attr.mul_fixed) begin
         sw_en_q <= pll_en_wdata;
      end
   end

   assign go_sleep = sleep_req && !wake_evt;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
      end else if (wake_evt) begin
         asleep_q <= 1'b0;
      end else if (sleep_req) begin
         asleep_q <= 1'b1;
      end
   end

   assign mul_want = attr.mul_ok && (attr.mul_fixed || sw_en_q);

   clkmode_timer #(.LIMIT(LOCK_CYCLES)) u_lock_tmr (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .restart (wake_evt || !mul_want),
      .run     (!asleep_q),
      .done    (lock_done)
   );

   clkmode_timer #(.LIMIT(START_CYCLES)) u_start_tmr (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .restart (wake_evt),
      .run     (!asleep_q),
      .done    (start_done)
   );

   assign start_ok = start_done || !attr.ext_src;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
      end else if (asleep_q || go_sleep) begin
         ready_q <= 1'b0;
      end else if (start_ok && (!mul_want || (lock_done && pll_lock))) begin
         ready_q <= 1'b1;
      end
   end

   assign pll_enable = mul_want && !asleep_q;
   assign clk_sel_4x = pll_enable && lock_done && pll_lock;
   assign exec_ready = ready_q;

   clkmode_auxpin #(.DIV_LOG2(DIV_LOG2)) u_aux (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .drive_clk    (attr.ext_src),
      .hand_to_port (attr.ext_src && attr.aux_gpio),
      .gpio_out     (gpio_out),
      .gpio_oe      (gpio_oe),
      .aux_out      (aux_out),
      .aux_oe       (aux_oe)
   );

endmodule

// File: rtl/clkmode_pll_ctrl_chk.sv
module clkmode_pll_ctrl_chk #(
   parameter int MODE_W = 4
) (
   input logic              clk_ref,
   input logic              rst_n,
   input logic              sleep_req,
   input logic              wake_evt,
   input logic [MODE_W-1:0] mode_cfg,
   input logic              pll_lock,
   input logic              gpio_out,
   input logic              gpio_oe,
   input logic              clk_sel_4x,
   input logic              pll_enable,
   input logic              exec_ready,
   input logic              aux_out,
   input logic              aux_oe
);

   logic m_off, m_fixed, m_io, m_xtal;
   assign m_off   = (mode_cfg == 0) || (mode_cfg == 1) || (mode_cfg == 3) || (mode_cfg > 8);
   assign m_fixed = (mode_cfg == 6) || (mode_cfg == 7) || (mode_cfg == 8);
   assign m_io    = (mode_cfg == 5) || (mode_cfg == 8);
   assign m_xtal  = (mode_cfg <= 3) || (mode_cfg == 6);

   p_off_modes_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      m_off |-> (!pll_enable && !clk_sel_4x));

   p_fixed_on_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (m_fixed && exec_ready) |-> pll_enable);

   p_ready_hold_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (exec_ready && !(sleep_req && !wake_evt)) |=> exec_ready);

   p_gpio_pass_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      m_io |-> (aux_out == gpio_out && aux_oe == gpio_oe));

   p_xtal_pin_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      m_xtal |-> (!aux_oe && !aux_out));

   p_sleep_off_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (sleep_req && !wake_evt) |=> (!exec_ready && !pll_enable));

   p_sel_lock_r11: assert property (@(posedge clk_ref) disable iff (!rst_n)
      clk_sel_4x |-> (pll_lock && pll_enable));

endmodule

bind clkmode_pll_ctrl clkmode_pll_ctrl_chk #(.MODE_W(MODE_W)) u_chk (.*);

// File: tb/clkmode_pll_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_pll_ctrl_tb;

   localparam int L = 9;
   localparam int S = 5;

   logic clk_ref = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_evt = 1'b0;
   logic [3:0] mode_cfg = '0;
   logic pll_en_wr = 1'b0, pll_en_wdata = 1'b0;
   logic pll_lock = 1'b1;
   logic gpio_out = 1'b0, gpio_oe = 1'b0;
   logic clk_sel_4x, pll_enable, exec_ready, aux_out, aux_oe;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk_ref = ~clk_ref;

   clkmode_pll_ctrl #(.LOCK_CYCLES(L), .START_CYCLES(S), .MODE_W(4)) u_dut (
      .clk_ref(clk_ref), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
      .mode_cfg(mode_cfg), .pll_en_wr(pll_en_wr), .pll_en_wdata(pll_en_wdata),
      .pll_lock(pll_lock), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .clk_sel_4x(clk_sel_4x), .pll_enable(pll_enable), .exec_ready(exec_ready),
      .aux_out(aux_out), .aux_oe(aux_oe));

   function automatic bit f_ok(int m);    return m == 2 || (m >= 4 && m <= 8); endfunction
   function automatic bit f_fixed(int m); return m >= 6 && m <= 8; endfunction
   function automatic bit f_ext(int m);   return m == 4 || m == 5 || m >= 7; endfunction
   function automatic bit f_io(int m);    return m == 5 || m == 8; endfunction
   function automatic int f_max(int a, int b); return (a > b) ? a : b; endfunction

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk_ref); @(negedge clk_ref);
   endtask

   task automatic write_en(bit v);
      pll_en_wr = 1'b1; pll_en_wdata = v;
      @(posedge clk_ref); #1;
      pll_en_wr = 1'b0;
      @(negedge clk_ref);
   endtask

   // reset in mode m, sweep aux pin and measure ready edge
   task automatic reset_sweep(int m);
      int n; int exp_rdy; bit aux_bad; int sv, lv;
      rst_n = 1'b0; mode_cfg = 4'(m); pll_lock = 1'b1;
      repeat (2) @(negedge clk_ref);
      check($sformatf("R5 reset ready m%0d", m), exec_ready, 0);
      check($sformatf("R10 reset sel m%0d", m), clk_sel_4x, 0);
      rst_n = 1'b1;
      sv = f_ext(m) ? S : 0;
      lv = f_fixed(m) ? L : 0;
      exp_rdy = f_max(sv, lv) + 1;
      n = 0; aux_bad = 1'b0;
      while (n < 40) begin
         gpio_out = n[0]; gpio_oe = n[1];
         tick(); n++;
         #1;
         if (f_io(m)) begin
            if (aux_out !== gpio_out || aux_oe !== gpio_oe) aux_bad = 1'b1;
         end else if (f_ext(m)) begin
            if (aux_oe !== 1'b1 || aux_out !== ((n % 4) >= 2)) aux_bad = 1'b1;
         end else begin
            if (aux_oe !== 1'b0 || aux_out !== 1'b0) aux_bad = 1'b1;
         end
         if (exec_ready && n >= exp_rdy + 4) break;
         if (exec_ready && n < exp_rdy) break;
      end
      check($sformatf("R6 R7 R8 aux pin m%0d", m), aux_bad, 0);
      check($sformatf("R4 R2 enable after reset m%0d", m), pll_enable, f_fixed(m));
      check($sformatf("R1 sel after reset m%0d", m), clk_sel_4x, f_fixed(m));
   endtask

   task automatic ready_edge(int m);
      int n;
      rst_n = 1'b0; mode_cfg = 4'(m);
      repeat (2) @(negedge clk_ref);
      rst_n = 1'b1;
      n = 0;
      while (!exec_ready && n < 40) begin tick(); n++; end
      check($sformatf("R5 ready edge m%0d", m), n,
            f_max(f_ext(m) ? S : 0, f_fixed(m) ? L : 0) + 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk_ref);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int n;
      @(negedge clk_ref);
      for (int m = 0; m < 16; m++) begin
         ready_edge(m);
         reset_sweep(m);
         // software enable write in every mode
         write_en(1'b1);
         check($sformatf("R1 R2 R4 enable after write m%0d", m), pll_enable, f_ok(m));
         n = 1;
         while (!clk_sel_4x && n < 30) begin tick(); n++; end
         if (f_ok(m) && !f_fixed(m))
            check($sformatf("R3 lock edges m%0d", m), n, L + 1);
         else if (f_fixed(m))
            check($sformatf("R4 sel kept m%0d", m), n, 1);
         else
            check($sformatf("R1 write ignored m%0d", m), clk_sel_4x, 0);
         if (f_fixed(m)) begin
            write_en(1'b0);
            check($sformatf("R4 clear ignored m%0d", m), pll_enable, 1);
         end
      end

      // lock loss follows in the same cycle
      reset_sweep(4);
      write_en(1'b1);
      repeat (L + 2) tick();
      check("R3 sel up", clk_sel_4x, 1);
      pll_lock = 1'b0; #1;
      check("R11 sel drops on lock loss", clk_sel_4x, 0);
      pll_lock = 1'b1; #1;
      check("R11 sel back with lock", clk_sel_4x, 1);

      // reset clears a set software bit
      rst_n = 1'b0; repeat (2) @(negedge clk_ref); rst_n = 1'b1;
      repeat (3) tick();
      check("R10 bit cleared by reset", pll_enable, 0);

      // sleep and wake in forced external mode and a crystal mode
      foreach (mode_cfg[i]) ;
      for (int k = 0; k < 2; k++) begin
         int m; int exp;
         m = (k == 0) ? 7 : 1;
         ready_edge(m);
         sleep_req = 1'b1; @(posedge clk_ref); #1; sleep_req = 1'b0;
         @(negedge clk_ref);
         check($sformatf("R9 ready off in sleep m%0d", m), exec_ready, 0);
         check($sformatf("R9 enable off in sleep m%0d", m), pll_enable, 0);
         repeat (4) tick();
         check($sformatf("R9 still asleep m%0d", m), exec_ready, 0);
         wake_evt = 1'b1; @(posedge clk_ref); #1; wake_evt = 1'b0;
         @(negedge clk_ref);
         n = 1;
         while (!exec_ready && n < 40) begin tick(); n++; end
         exp = f_max(f_ext(m) ? S : 0, f_fixed(m) ? L : 0) + 2;
         check($sformatf("R9 ready after wake m%0d", m), n, exp);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule